// File: doc/BRIEF.md
# Banked Shift-Buffer Operand Shifter

This block sits in front of the ALU of a 16-bit datapath and prepares the second operand. It moves a source word by one to four bit positions in one of five ways. A 4-bit shift buffer takes part in every move. Plain shifts drop the bits they push out into the buffer. Rotates treat the word and the buffer as one 20-bit ring. There is one buffer for each of three processor modes: normal, fast interrupt and interrupt. The mode input picks the buffer, so software never saves or restores it when the processor changes mode.

Operands arrive on a valid/ready input stream and leave on a valid/ready output stream through one register stage. The source is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output holds still and no new beat is taken. The control fields and the commit strobe travel with the data beat. A beat that is not accepted has no effect on any buffer.

Top module: `opshift_sb`

## Requirements
- R1: Op code 0 is arithmetic right by n (n = `in_amt`, 1 to 4). The result is the source shifted right, with bit 15 copied into the top n bits. The new buffer is {src[n-1:0], buf[3:n]}.
- R2: Op code 2 is logical right by n. Zeros fill the top n bits of the result, and the buffer is updated exactly as in R1.
- R3: Op code 1 is logical left by n. Zeros fill the low n bits of the result, and the new buffer is {buf[3-n:0], src[15:16-n]}.
- R4: Op code 4 rotates the 20-bit ring {src, buf} right by n. The result is {buf[n-1:0], src[15:n]} and the new buffer is {src[n-1:0], buf[3:n]}.
- R5: Op code 3 rotates the 20-bit ring {buf, src} left by n. The result is {src[15-n:0], buf[3:4-n]} and the new buffer is {buf[3-n:0], src[15:16-n]}.
- R6: An amount of 0 or above 4, or an op code from 5 to 7, makes the beat a bypass. The source appears unchanged on `out_data` and no buffer is written.
- R7: Mode 0 selects the normal buffer, mode 1 the fast-interrupt buffer and mode 2 the interrupt buffer. Mode 3 uses the normal buffer. A beat reads and writes only the buffer its mode selects.
- R8: The selected buffer takes its new value only when an accepted, non-bypass beat has `in_commit` high. `out_sb` shows the selected buffer's content after the beat.
- R9: `out_neg` equals bit 15 of `out_data`. `out_zero` is high exactly when `out_data` is zero.
- R10: `in_ready` = !`out_valid` || `out_ready`. While the output is stalled, `out_data` and `out_valid` hold, and a beat offered in that time writes no buffer.
- R11: After reset `out_valid` is low and all three buffers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | 16 | Source word |
| in_op | input | 3 | Operation code |
| in_amt | input | 3 | Shift amount |
| in_mode | input | 2 | Processor mode selecting the buffer |
| in_commit | input | 1 | Write the new buffer value back |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 16 | Shifted operand |
| out_sb | output | 4 | Selected buffer after the beat |
| out_neg | output | 1 | Sign of the result |
| out_zero | output | 1 | Result is zero |

## Verification
A buffer write-back and an output stall can fall in the same cycle: a committing beat may be offered while the output register is full and the consumer holds `out_ready` low. The bench makes this happen by accepting one committing beat and then dropping `out_ready`. It then offers a second committing rotate on the same mode. The bench judges the outcome in two steps. First, the output must keep the first result and `in_ready` must stay low. Second, after the stall is released, a bypass read of that mode must show the buffer exactly as the first beat left it. Random traffic then mixes all modes, codes and amounts, and the result of every beat is compared with a bit-by-bit reference model.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_ASR = 3'd0;
  localparam logic [OP_W-1:0] OP_LSL = 3'd1;
  localparam logic [OP_W-1:0] OP_LSR = 3'd2;
  localparam logic [OP_W-1:0] OP_ROL = 3'd3;
  localparam logic [OP_W-1:0] OP_ROR = 3'd4;
endpackage

// File: rtl/opshift_core.sv
module opshift_core
  import opshift_pkg::*;
#(
  parameter int W   = 16,
  parameter int SBW = 4,
  parameter int AW  = 3
) (
  input  logic [W-1:0]    src,
  input  logic [SBW-1:0]  sb_in,
  input  logic [OP_W-1:0] op,
  input  logic [AW-1:0]   amt,
  output logic [W-1:0]    res,
  output logic [SBW-1:0]  sb_out,
  output logic            active
);
  localparam int RING = W + SBW;

  logic [2*RING-1:0] dbl_r;
  logic [2*RING-1:0] dbl_l;
  logic              amt_ok;
  logic              op_ok;

  assign amt_ok = (amt != '0) && (int'(amt) <= SBW);
  assign op_ok  = (op <= OP_ROR);
  assign active = amt_ok && op_ok;

  // Doubled rings: a plain shift of the copy yields the rotation in one window.
  assign dbl_r = {src, sb_in, src, sb_in} >> amt;
  assign dbl_l = {sb_in, src, sb_in, src} << amt;

  always_comb begin
    res    = src;
    sb_out = sb_in;
    if (active) begin
      case (op)
        OP_ASR: begin
          res    = W'($signed(src) >>> amt);
          sb_out = dbl_r[SBW-1:0];
        end
        OP_LSR: begin
          res    = src >> amt;
          sb_out = dbl_r[SBW-1:0];
        end
        OP_ROR: begin
          res    = dbl_r[RING-1:SBW];
          sb_out = dbl_r[SBW-1:0];
        end
        OP_LSL: begin
          res    = src << amt;
          sb_out = dbl_l[2*RING-1 -: SBW];
        end
        OP_ROL: begin
          res    = dbl_l[RING+W-1:RING];
          sb_out = dbl_l[2*RING-1 -: SBW];
        end
        default: begin
          res    = src;
          sb_out = sb_in;
        end
      endcase
    end
  end
endmodule

// File: rtl/opshift_bank.sv
module opshift_bank #(
  parameter int SBW    = 4,
  parameter int NMODES = 3,
  parameter int MW     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [MW-1:0]  mode,
  input  logic           we,
  input  logic [SBW-1:0] wdata,
  output logic [SBW-1:0] rdata
);
  logic [MW-1:0]  sel;
  logic [SBW-1:0] bank_q [NMODES];

  // Codes with no bank of their own fall back to the normal bank.
  assign sel = (int'(mode) < NMODES) ? mode : '0;

  for (genvar m = 0; m < NMODES; m++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bank_q[m] <= '0;
      else if (we && (sel == MW'(m)))      bank_q[m] <= wdata;
    end

    AST_BANK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != MW'(m)) |=> $stable(bank_q[m])); // R7
  end

  always_comb begin
    rdata = bank_q[0];
    for (int m = 0; m < NMODES; m++)
      if (sel == MW'(m)) rdata = bank_q[m];
  end

  AST_BANK_NO_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($past(rdata) == bank_q[$past(sel)])); // R8
endmodule

// File: rtl/opshift_sb.sv
module opshift_sb
  import opshift_pkg::*;
#(
  parameter int W      = 16,
  parameter int SBW    = 4,
  parameter int AW     = 3,
  parameter int NMODES = 3,
  parameter int MW     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_data,
  input  logic [OP_W-1:0] in_op,
  input  logic [AW-1:0]   in_amt,
  input  logic [MW-1:0]   in_mode,
  input  logic            in_commit,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_data,
  output logic [SBW-1:0]  out_sb,
  output logic            out_neg,
  output logic            out_zero
);
  logic           accept;
  logic           active;
  logic           wr_en;
  logic [SBW-1:0] sb_cur;
  logic [SBW-1:0] sb_new;
  logic [W-1:0]   shifted;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign wr_en    = accept && in_commit && active;

  opshift_bank #(.SBW(SBW), .NMODES(NMODES), .MW(MW)) bank_i (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (in_mode),
    .we    (wr_en),
    .wdata (sb_new),
    .rdata (sb_cur)
  );

  opshift_core #(.W(W), .SBW(SBW), .AW(AW)) core_i (
    .src    (in_data),
    .sb_in  (sb_cur),
    .op     (in_op),
    .amt    (in_amt),
    .res    (shifted),
    .sb_out (sb_new),
    .active (active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sb    <= '0;
      out_neg   <= 1'b0;
      out_zero  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= shifted;
        out_sb    <= (in_commit && active) ? sb_new : sb_cur;
        out_neg   <= shifted[W-1];
        out_zero  <= (shifted == '0);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10
  AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_amt == '0)) |=> (out_data == $past(in_data))); // R6
  AST_ASR_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && active && (in_op == OP_ASR)) |=> (out_data[W-1] == $past(in_data[W-1]))); // R1
  AST_LSL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && active && (in_op == OP_LSL)) |=> !out_data[0]); // R3
endmodule

// File: tb/opshift_sb_tb_top.sv
`timescale 1ns/1ps
module opshift_sb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_commit;
  logic [15:0] in_data;
  logic [2:0]  in_op, in_amt;
  logic [1:0]  in_mode;
  logic        out_valid, out_ready;
  logic [15:0] out_data;
  logic [3:0]  out_sb;
  logic        out_neg, out_zero;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [3:0] sb_model [3];

  always #2.5 clk = ~clk;

  opshift_sb dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_op(in_op), .in_amt(in_amt), .in_mode(in_mode),
    .in_commit(in_commit), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sb(out_sb), .out_neg(out_neg), .out_zero(out_zero)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: n single-bit steps on the word and buffer.
  function automatic void ref_shift(input logic [15:0] s, input logic [3:0] b,
                                    input logic [2:0] op, input logic [2:0] n,
                                    output logic [15:0] r, output logic [3:0] nb);
    logic [15:0] w = s;
    logic [3:0]  q = b;
    for (int i = 0; i < int'(n); i++) begin
      logic [15:0] w0 = w;
      logic [3:0]  q0 = q;
      case (op)
        3'd0: begin w = {w0[15], w0[15:1]}; q = {w0[0], q0[3:1]}; end
        3'd2: begin w = {1'b0, w0[15:1]};   q = {w0[0], q0[3:1]}; end
        3'd4: begin w = {q0[0], w0[15:1]};  q = {w0[0], q0[3:1]}; end
        3'd1: begin w = {w0[14:0], 1'b0};   q = {q0[2:0], w0[15]}; end
        default: begin w = {w0[14:0], q0[3]}; q = {q0[2:0], w0[15]}; end
      endcase
    end
    r = w;
    nb = q;
  endfunction

  function automatic string tag_of(input logic [2:0] op, input bit act);
    if (!act) return "R6 bypass";
    case (op)
      3'd0: return "R1 asr";
      3'd2: return "R2 lsr";
      3'd1: return "R3 lsl";
      3'd4: return "R4 ror";
      default: return "R5 rol";
    endcase
  endfunction

  task automatic beat(input logic [15:0] d, input logic [2:0] op, input logic [2:0] n,
                      input logic [1:0] mode, input bit commit);
    logic [15:0] er;
    logic [3:0]  eb;
    int   bi  = (mode == 2'd3) ? 0 : int'(mode);
    bit   act = (n != 0) && (n <= 4) && (op <= 4);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_op = op; in_amt = n; in_mode = mode; in_commit = commit;
    if (act) ref_shift(d, sb_model[bi], op, n, er, eb);
    else begin er = d; eb = sb_model[bi]; end
    if (act && commit) sb_model[bi] = eb;
    @(posedge clk); #1;
    check(tag_of(op, act), 32'(out_data), 32'(er));
    check("R8 R7 buffer", 32'(out_sb), 32'(sb_model[bi]));
    check("R9 flags", {30'd0, out_neg, out_zero}, {30'd0, er[15], (er == 16'd0)});
  endtask

  initial begin
    void'($urandom(7));
    for (int m = 0; m < 3; m++) sb_model[m] = 4'd0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_data = '0; in_op = '0; in_amt = '0; in_mode = '0; in_commit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 out_valid after reset", 32'(out_valid), 32'd0);
    check("R10 ready after reset", 32'(in_ready), 32'd1);
    @(negedge clk); rst_n = 1'b1;

    // R11: every bank reads zero
    for (int m = 0; m < 3; m++) beat(16'h1234, 3'd0, 3'd0, 2'(m), 1'b0);
    // Directed ring walk in the fast bank; R4 then R5
    beat(16'h0001, 3'd4, 3'd1, 2'd1, 1'b1);
    check("R4 ror into buffer", 32'(out_sb), 32'h8);
    beat(16'h0000, 3'd3, 3'd1, 2'd1, 1'b1);
    check("R5 rol out of buffer", 32'(out_data), 32'h1);
    beat(16'hF00F, 3'd4, 3'd4, 2'd1, 1'b1);
    // R7: other banks untouched, mode 3 aliases normal
    beat(16'h0, 3'd0, 3'd0, 2'd0, 1'b0);
    check("R7 normal bank clean", 32'(out_sb), 32'h0);
    beat(16'h0, 3'd0, 3'd0, 2'd2, 1'b0);
    check("R7 irq bank clean", 32'(out_sb), 32'h0);
    beat(16'h8001, 3'd0, 3'd4, 2'd3, 1'b1);
    beat(16'h0, 3'd7, 3'd2, 2'd0, 1'b0);
    // R8: non-commit leaves buffer; R6: reserved amount/op
    beat(16'hFFFF, 3'd1, 3'd3, 2'd2, 1'b0);
    beat(16'hABCD, 3'd2, 3'd5, 2'd2, 1'b1);
    beat(16'h8000, 3'd2, 3'd4, 2'd2, 1'b1);
    beat(16'h0000, 3'd0, 3'd0, 2'd2, 1'b0);

    // R10: commit offered while the output is stalled
    beat(16'h00F3, 3'd4, 3'd2, 2'd2, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    in_data = 16'h5555; in_op = 3'd4; in_amt = 3'd3; in_mode = 2'd2; in_commit = 1'b1;
    @(posedge clk); #1;
    check("R10 held data", 32'(out_data), 32'(16'h00F3 >> 2) | 32'({sb_model[2][1:0], 14'd0}) & 32'hC000);
    check("R10 ready low", 32'(in_ready), 32'd0);
    check("R10 valid held", 32'(out_valid), 32'd1);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); #1;
    check("R10 drained", 32'(out_valid), 32'd0);
    beat(16'h0, 3'd0, 3'd0, 2'd2, 1'b0);
    check("R10 stalled beat wrote nothing", 32'(out_sb), 32'(sb_model[2]));

    // Random traffic
    for (int k = 0; k < 600; k++)
      beat(16'($urandom), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 5)),
           2'($urandom_range(0, 3)), bit'($urandom_range(0, 3) != 0));

    @(negedge clk); in_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule